// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns a one-hot operation request into the command, address and second-command byte phases of a NAND flash bus. Software writes one operation bit. If no operation is already pending, the block latches the request and the chip select, works out how many address bytes to send, and then walks through the phases. Each byte is held on the I/O bus for a programmable number of clocks. The write strobe is pulsed low for one clock in the middle of that window. The command-latch strobe is raised for command bytes and the address-latch strobe for address bytes.

Some operations finish as soon as their bytes are out. Others leave the operation pending while a data phase, handled outside this block, moves the payload. When that data phase ends, the `data_done` pulse tells the sequencer. A page program then issues its confirming second command byte. Every operation ends with a one-cycle completion pulse. The block also reports the data-phase length, which is halved in double-data-rate mode for the short register-style transfers.

Top module: `nand_seq_ctrl`

## Requirements
- R1: A write with `op_wr_en` is accepted only when it has exactly one bit set and no operation is pending. Any other write is ignored and leaves the pending operation, bus and outputs untouched. Bit encoding: 0 reset, 1 read-ID, 2 read-status, 3 enhanced read-status, 4 get-features, 5 set-features, 6 read-parameter-page, 7 page read, 8 page program, 9 block erase.
- R2: Each command or address byte is held for E = max(`hold_clks`, 2) clocks. `nand_we_n` is low for exactly one of those clocks, at offset E/2 (integer division) from the start of the byte. During command bytes `nand_cle` is 1 and `nand_ale` is 0. During address bytes `nand_ale` is 1 and `nand_cle` is 0.
- R3: Read-ID, block erase and page read send `addr_cnt` address bytes (nominally 1, 3 and 5). The other operations use a fixed count whatever `addr_cnt` holds: reset 0, read-status 0, enhanced read-status 3, get-features 1, set-features 1, read-parameter-page 1, page program 5.
- R4: Reset sends `cmd1` only and then completes at once. Block erase sends `cmd1`, its address bytes and `cmd2`, and then completes at once.
- R5: Page read sends `cmd1`, its address bytes and `cmd2`, and then waits. It completes when `data_done` is pulsed. The other read-type operations send `cmd1` and their address bytes, and then wait in the same way.
- R6: Page program sends `cmd1` and five address bytes, and then waits. A `data_done` pulse makes it send `cmd2`, after which it completes.
- R7: Address byte k (k = 0 to 3) is bits 8k+7:8k of `addr_lo`. Address byte 4 is `addr_hi[7:0]`. Bytes go out in order of increasing k.
- R8: A count above 5 sends the five address bytes and no more. The remaining phases run normally, and `addr_err` pulses for one clock when the operation is accepted.
- R9: The chip select is `addr_hi[31:30]`, captured at acceptance. While an operation is pending, exactly that line of `nand_ce_n` is low. With no operation pending, all lines are high.
- R10: `xfer_len` equals `pkt_size`. It equals `pkt_size/2` when `ddr_mode` is 1 and the pending operation is read-ID, read-status, enhanced read-status, get-features or set-features.
- R11: `busy` is 1 from the clock after acceptance until the last byte window of a phase run ends. It is 0 while waiting for `data_done` and while idle.
- R12: `done` is a one-clock pulse at completion, and the pending operation clears at the same time. After reset there is no pending operation, the strobes are inactive (`nand_we_n` high, `nand_cle` and `nand_ale` low) and `busy`, `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wr_en | input | 1 | Operation register write strobe |
| op_wr_data | input | 10 | One-hot operation value |
| cmd1 | input | 8 | First command byte |
| cmd2 | input | 8 | Second command byte |
| addr_cnt | input | 3 | Programmed address byte count |
| addr_lo | input | 32 | Address bytes 0 to 3 |
| addr_hi | input | 32 | Address byte 4 in [7:0], chip select in [31:30] |
| hold_clks | input | 4 | Clocks per bus byte (minimum 2 applied) |
| pkt_size | input | 11 | Programmed data packet size |
| ddr_mode | input | 1 | Double-data-rate data interface selected |
| data_done | input | 1 | External data phase finished |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | I/O byte |
| nand_ce_n | output | 4 | Chip enables, active low |
| xfer_len | output | 11 | Data phase length for the pending operation |
| busy | output | 1 | Phases being issued |
| done | output | 1 | Completion pulse |
| addr_err | output | 1 | Address count above five requested |

## Verification
The bench records every strobed byte together with its latch-enable state. It compares each operation's byte sequence against its recipe, which catches a design that uses the programmed count where a fixed one applies, or that sends the second command of a program before the data phase ends. A count of seven checks the address limit: a faulty design would read past byte four or drop the second command. A write arriving while a read is pending must change nothing, and a design that accepted it would emit erase bytes or lose the read. Minimum and odd hold values check that the strobe lands mid-window and that each byte lasts the right number of clocks.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int OP_W = 10;

    localparam int OP_RST   = 0;
    localparam int OP_RDID  = 1;
    localparam int OP_STAT  = 2;
    localparam int OP_STATX = 3;
    localparam int OP_GETF  = 4;
    localparam int OP_SETF  = 5;
    localparam int OP_PARAM = 6;
    localparam int OP_PREAD = 7;
    localparam int OP_PROG  = 8;
    localparam int OP_ERASE = 9;

    localparam int MAX_ADDR_BYTES = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_CMD2,
        ST_WAIT
    } seq_state_t;

    typedef struct packed {
        logic [2:0] fixed_cnt;
        logic       use_prog;
        logic       early_cmd2;
        logic       late_cmd2;
        logic       instant;
        logic       ddr_half;
    } recipe_t;

endpackage

// File: rtl/nseq_recipe.sv
module nseq_recipe
    import nseq_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output recipe_t         rec
);
    always_comb begin
        rec = '0;
        case (1'b1)
            op[OP_RST]:   begin rec.fixed_cnt = 3'd0; rec.instant = 1'b1; end
            op[OP_RDID]:  begin rec.use_prog = 1'b1; rec.ddr_half = 1'b1; end
            op[OP_STAT]:  begin rec.fixed_cnt = 3'd0; rec.ddr_half = 1'b1; end
            op[OP_STATX]: begin rec.fixed_cnt = 3'd3; rec.ddr_half = 1'b1; end
            op[OP_GETF]:  begin rec.fixed_cnt = 3'd1; rec.ddr_half = 1'b1; end
            op[OP_SETF]:  begin rec.fixed_cnt = 3'd1; rec.ddr_half = 1'b1; end
            op[OP_PARAM]: rec.fixed_cnt = 3'd1;
            op[OP_PREAD]: begin rec.use_prog = 1'b1; rec.early_cmd2 = 1'b1; end
            op[OP_PROG]:  begin rec.fixed_cnt = 3'd5; rec.late_cmd2 = 1'b1; end
            op[OP_ERASE]: begin
                rec.use_prog   = 1'b1;
                rec.early_cmd2 = 1'b1;
                rec.instant    = 1'b1;
            end
            default: rec = '0;
        endcase
    end
endmodule

// File: rtl/nseq_addr_sel.sv
module nseq_addr_sel #(
    parameter int IDX_W = 3
) (
    input  logic [31:0]      addr_lo,
    input  logic [31:0]      addr_hi,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       addr_byte
);
    localparam int SLOTS = 1 << IDX_W;

    logic [7:0] slot [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < 4) begin : g_lo
            assign slot[g] = addr_lo[8*g +: 8];
        end else if (g == 4) begin : g_hi
            assign slot[g] = addr_hi[7:0];
        end else begin : g_none
            assign slot[g] = 8'h00;
        end
    end

    assign addr_byte = slot[idx];
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nseq_pkg::*;
#(
    parameter int CS_W   = 2,
    parameter int HOLD_W = 4,
    parameter int PKT_W  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_wr_en,
    input  logic [OP_W-1:0]      op_wr_data,
    input  logic [7:0]           cmd1,
    input  logic [7:0]           cmd2,
    input  logic [2:0]           addr_cnt,
    input  logic [31:0]          addr_lo,
    input  logic [31:0]          addr_hi,
    input  logic [HOLD_W-1:0]    hold_clks,
    input  logic [PKT_W-1:0]     pkt_size,
    input  logic                 ddr_mode,
    input  logic                 data_done,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic [7:0]           nand_io,
    output logic [(1<<CS_W)-1:0] nand_ce_n,
    output logic [PKT_W-1:0]     xfer_len,
    output logic                 busy,
    output logic                 done,
    output logic                 addr_err
);
    localparam int NUM_CS = 1 << CS_W;
    localparam logic [HOLD_W-1:0] HOLD_MIN = HOLD_W'(2);

    typedef struct packed {
        seq_state_t       st;
        logic [OP_W-1:0]  op;
        logic [2:0]       idx;
        logic [2:0]       total;
        logic [HOLD_W-1:0] cnt;
        logic [CS_W-1:0]  cs;
        logic             done;
        logic             err;
    } seq_regs_t;

    seq_regs_t q, d;
    recipe_t   rec_new, rec_cur;
    logic [7:0] addr_byte;
    logic [HOLD_W-1:0] eff_hold;
    logic [2:0] req_cnt;
    logic last_tick, accept, in_phase;

    nseq_recipe u_rec_new (.op(op_wr_data), .rec(rec_new));
    nseq_recipe u_rec_cur (.op(q.op),       .rec(rec_cur));

    nseq_addr_sel #(.IDX_W(3)) u_addr (
        .addr_lo(addr_lo), .addr_hi(addr_hi), .idx(q.idx), .addr_byte(addr_byte)
    );

    assign eff_hold  = (hold_clks < HOLD_MIN) ? HOLD_MIN : hold_clks;
    assign in_phase  = (q.st == ST_CMD1) || (q.st == ST_ADDR) || (q.st == ST_CMD2);
    assign last_tick = (q.cnt == eff_hold - HOLD_W'(1));
    assign accept    = op_wr_en && $onehot(op_wr_data) && (q.op == '0);
    assign req_cnt   = rec_new.use_prog ? addr_cnt : rec_new.fixed_cnt;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        if (in_phase) begin
            d.cnt = last_tick ? '0 : q.cnt + HOLD_W'(1);
        end
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st    = ST_CMD1;
                    d.op    = op_wr_data;
                    d.cnt   = '0;
                    d.idx   = '0;
                    d.total = (req_cnt > 3'(MAX_ADDR_BYTES)) ? 3'(MAX_ADDR_BYTES) : req_cnt;
                    d.err   = (req_cnt > 3'(MAX_ADDR_BYTES));
                    d.cs    = addr_hi[31 -: CS_W];
                end
            end
            ST_CMD1: begin
                if (last_tick) begin
                    if (q.total != 3'd0)          d.st = ST_ADDR;
                    else if (rec_cur.early_cmd2)  d.st = ST_CMD2;
                    else if (rec_cur.instant) begin
                        d.st = ST_IDLE; d.op = '0; d.done = 1'b1;
                    end else                      d.st = ST_WAIT;
                end
            end
            ST_ADDR: begin
                if (last_tick) begin
                    if (q.idx == q.total - 3'd1) begin
                        d.idx = '0;
                        if (rec_cur.early_cmd2)   d.st = ST_CMD2;
                        else if (rec_cur.instant) begin
                            d.st = ST_IDLE; d.op = '0; d.done = 1'b1;
                        end else                  d.st = ST_WAIT;
                    end else begin
                        d.idx = q.idx + 3'd1;
                    end
                end
            end
            ST_CMD2: begin
                if (last_tick) begin
                    if (rec_cur.instant || rec_cur.late_cmd2) begin
                        d.st = ST_IDLE; d.op = '0; d.done = 1'b1;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (data_done) begin
                    if (rec_cur.late_cmd2) begin
                        d.st  = ST_CMD2;
                        d.cnt = '0;
                    end else begin
                        d.st = ST_IDLE; d.op = '0; d.done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        nand_cle  = (q.st == ST_CMD1) || (q.st == ST_CMD2);
        nand_ale  = (q.st == ST_ADDR);
        nand_we_n = !(in_phase && (q.cnt == (eff_hold >> 1)));
        case (q.st)
            ST_CMD1: nand_io = cmd1;
            ST_CMD2: nand_io = cmd2;
            ST_ADDR: nand_io = addr_byte;
            default: nand_io = 8'h00;
        endcase
        nand_ce_n = '1;
        if (q.op != '0) nand_ce_n[q.cs] = 1'b0;
        xfer_len = (ddr_mode && rec_cur.ddr_half) ? (pkt_size >> 1) : pkt_size;
        busy     = in_phase;
        done     = q.done;
        addr_err = q.err;
    end

    AST_ONEHOT_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.op)); // R1
    AST_REJECT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr_en && q.op != '0) |=> (q.op == $past(q.op) || q.op == '0)); // R1
    AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (nand_cle ^ nand_ale)); // R2
    AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ale |-> (q.idx < 3'(MAX_ADDR_BYTES))); // R8
    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~nand_ce_n) <= 1); // R9
    AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.op != '0)); // R11
    AST_DONE_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(q.op) != '0)); // R12

    initial begin
        AST_CS_COUNT: assert (NUM_CS >= 2); // R9
    end
endmodule

// File: tb/nand_seq_ctrl_test.sv
`timescale 1ns/1ps
module nand_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_wr_en = 1'b0;
    logic [9:0]  op_wr_data = '0;
    logic [7:0]  cmd1 = '0, cmd2 = '0;
    logic [2:0]  addr_cnt = '0;
    logic [31:0] addr_lo = 32'h44332211, addr_hi = 32'h00000055;
    logic [3:0]  hold_clks = 4'd4;
    logic [10:0] pkt_size = 11'd200;
    logic        ddr_mode = 1'b0;
    logic        data_done = 1'b0;
    logic        nand_cle, nand_ale, nand_we_n, busy, done, addr_err;
    logic [7:0]  nand_io;
    logic [3:0]  nand_ce_n;
    logic [10:0] xfer_len;

    always #4 clk = ~clk;

    nand_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_wr_en(op_wr_en), .op_wr_data(op_wr_data),
        .cmd1(cmd1), .cmd2(cmd2), .addr_cnt(addr_cnt), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .hold_clks(hold_clks), .pkt_size(pkt_size),
        .ddr_mode(ddr_mode), .data_done(data_done), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_io(nand_io),
        .nand_ce_n(nand_ce_n), .xfer_len(xfer_len), .busy(busy), .done(done),
        .addr_err(addr_err)
    );

    int checks = 0, fails = 0;
    logic [9:0] lg [0:31];
    int n_log = 0, n_busy = 0, n_done = 0, n_err = 0, first_strobe = -1;

    always @(negedge clk) begin
        if (!nand_we_n && n_log < 32) begin
            lg[n_log] = {nand_cle, nand_ale, nand_io};
            n_log = n_log + 1;
        end
        if (busy) begin
            if (!nand_we_n && first_strobe < 0) first_strobe = n_busy;
            n_busy = n_busy + 1;
        end
        if (done) n_done = n_done + 1;
        if (addr_err) n_err = n_err + 1;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        @(negedge clk);
        n_log = 0; n_busy = 0; n_done = 0; n_err = 0; first_strobe = -1;
    endtask

    task automatic issue(logic [9:0] v);
        @(posedge clk); #1;
        op_wr_en = 1'b1; op_wr_data = v;
        @(posedge clk); #1;
        op_wr_en = 1'b0; op_wr_data = '0;
    endtask

    task automatic settle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_data_done();
        @(posedge clk); #1; data_done = 1'b1;
        @(posedge clk); #1; data_done = 1'b0;
        settle();
    endtask

    function automatic int ent(logic c, logic a, logic [7:0] b);
        return int'({c, a, b});
    endfunction

    task automatic t_reset_state();
        @(negedge clk);
        check("R12 busy after reset", busy, 0);
        check("R12 done after reset", done, 0);
        check("R12 we_n after reset", nand_we_n, 1);
        check("R12 cle/ale after reset", {nand_cle, nand_ale}, 0);
        check("R9 ce_n idle", nand_ce_n, 4'hF);
    endtask

    task automatic t_reset_op();
        hold_clks = 4'd4; cmd1 = 8'hFF; addr_cnt = 3'd4;
        clr(); issue(10'h001); settle();
        check("R4 reset byte count", n_log, 1);
        check("R4 reset cmd byte", lg[0], ent(1, 0, 8'hFF));
        check("R2 busy clocks E=4", n_busy, 4);
        check("R2 strobe offset E=4", first_strobe, 2);
        check("R12 reset done pulse", n_done, 1);
        check("R9 ce released", nand_ce_n, 4'hF);
    endtask

    task automatic t_hold_min();
        hold_clks = 4'd0; cmd1 = 8'hFF;
        clr(); issue(10'h001); settle();
        check("R2 busy clocks E=2", n_busy, 2);
        check("R2 strobe offset E=2", first_strobe, 1);
        hold_clks = 4'd5;
        clr(); issue(10'h001); settle();
        check("R2 busy clocks E=5", n_busy, 5);
        check("R2 strobe offset E=5", first_strobe, 2);
    endtask

    task automatic t_erase();
        hold_clks = 4'd3; cmd1 = 8'h60; cmd2 = 8'hD0; addr_cnt = 3'd3;
        clr(); issue(10'h200); settle();
        check("R4 erase count", n_log, 5);
        check("R4 erase cmd1", lg[0], ent(1, 0, 8'h60));
        check("R7 erase addr0", lg[1], ent(0, 1, 8'h11));
        check("R7 erase addr1", lg[2], ent(0, 1, 8'h22));
        check("R7 erase addr2", lg[3], ent(0, 1, 8'h33));
        check("R4 erase cmd2", lg[4], ent(1, 0, 8'hD0));
        check("R11 erase busy clocks", n_busy, 15);
        check("R4 erase done", n_done, 1);
    endtask

    task automatic t_page_read();
        hold_clks = 4'd2; cmd1 = 8'h00; cmd2 = 8'h30; addr_cnt = 3'd5; ddr_mode = 1'b1;
        clr(); issue(10'h080); settle();
        check("R5 page read count", n_log, 7);
        check("R7 addr3", lg[4], ent(0, 1, 8'h44));
        check("R7 addr4 from high reg", lg[5], ent(0, 1, 8'h55));
        check("R5 cmd2 before data", lg[6], ent(1, 0, 8'h30));
        check("R5 no done before data", n_done, 0);
        check("R11 busy low while waiting", busy, 0);
        check("R9 ce held while pending", nand_ce_n, 4'hE);
        check("R10 page read not halved", xfer_len, 200);
        pulse_data_done();
        check("R5 done after data", n_done, 1);
        check("R12 ce released after done", nand_ce_n, 4'hF);
        ddr_mode = 1'b0;
    endtask

    task automatic t_program();
        hold_clks = 4'd2; cmd1 = 8'h80; cmd2 = 8'h10; addr_cnt = 3'd2;
        clr(); issue(10'h100); settle();
        check("R3 program forced five addr", n_log, 6);
        check("R6 no cmd2 before data", lg[5], ent(0, 1, 8'h55));
        check("R6 no done before data", n_done, 0);
        pulse_data_done();
        check("R6 cmd2 after data", n_log, 7);
        check("R6 cmd2 byte", lg[6], ent(1, 0, 8'h10));
        check("R6 done", n_done, 1);
    endtask

    task automatic t_read_id();
        hold_clks = 4'd2; cmd1 = 8'h90; addr_cnt = 3'd1; ddr_mode = 1'b1;
        addr_hi = 32'h80000055;
        clr(); issue(10'h002); settle();
        check("R3 read id count", n_log, 2);
        check("R9 chip select 2", nand_ce_n, 4'hB);
        check("R10 ddr halved", xfer_len, 100);
        ddr_mode = 1'b0; #1;
        check("R10 sdr full", xfer_len, 200);
        pulse_data_done();
        check("R5 read id done", n_done, 1);
        addr_hi = 32'h00000055;
    endtask

    task automatic t_fixed_counts();
        hold_clks = 4'd2; cmd1 = 8'h70; addr_cnt = 3'd5;
        clr(); issue(10'h004); settle();
        check("R3 status zero addr", n_log, 1);
        pulse_data_done();
        clr(); issue(10'h008); settle();
        check("R3 enhanced status three addr", n_log, 4);
        pulse_data_done();
        addr_cnt = 3'd4;
        clr(); issue(10'h010); settle();
        check("R3 get features forced one", n_log, 2);
        pulse_data_done();
        check("R5 get features done", n_done, 1);
    endtask

    task automatic t_overflow();
        hold_clks = 4'd2; cmd1 = 8'h00; cmd2 = 8'h30; addr_cnt = 3'd7;
        clr(); issue(10'h080); settle();
        check("R8 five addr then cmd2", n_log, 7);
        check("R8 last is cmd2", lg[6], ent(1, 0, 8'h30));
        check("R8 err pulse", n_err, 1);
        pulse_data_done();
    endtask

    task automatic t_reject();
        hold_clks = 4'd2; cmd1 = 8'h00; cmd2 = 8'h30; addr_cnt = 3'd5;
        clr(); issue(10'h080); settle();
        cmd1 = 8'h60; cmd2 = 8'hD0;
        issue(10'h200); repeat (20) @(negedge clk);
        check("R1 pending write no bytes", n_log, 7);
        check("R1 pending write no busy", busy, 0);
        check("R1 pending write no done", n_done, 0);
        pulse_data_done();
        check("R1 original op completes", n_done, 1);
        check("R1 no erase bytes", n_log, 7);
        clr(); issue(10'h003); repeat (20) @(negedge clk);
        check("R1 non-onehot ignored", n_log, 0);
        check("R1 non-onehot ce idle", nand_ce_n, 4'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_reset_op();
        t_hold_min();
        t_erase();
        t_page_read();
        t_program();
        t_read_id();
        t_fixed_counts();
        t_overflow();
        t_reject();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule